// File: doc/BRIEF.md
# Gated Edge-Count Frequency Meter

This block measures the frequency of an already squared-up intermediate-frequency pulse stream. It counts the stream's rising edges over a gate window of known length. The window is timed by a strobe that pulses once per period of the slow 75 kHz timebase. Software configures the block with a single write that sets an input-mode code and a 2-bit gate-length code. A separate start pulse then launches the measurement. When the window closes, the edge total is transferred to the output register and a completion flag rises.

The block runs on a fast counting clock, which must be at least twice the highest input edge rate. The asynchronous input passes through a synchroniser and a rising-edge detector before it reaches a saturating accumulator whose width is a parameter (20 bits by default). An inhibit input blocks counting while the chip is in a low-power, halted or stopped state.

The controller has four states:
- **IDLE**: waiting.
- **ARM**: a start has been accepted and the block waits for the next timebase strobe.
- **GATE**: the window is open and edges are counted.
- **LATCH**: a one-cycle transfer of the total into the result register.

Its transitions are:
- IDLE→ARM on an accepted start.
- ARM→GATE on a strobe.
- GATE→LATCH on the strobe that ends the window.
- LATCH→IDLE unconditionally.
- ARM/GATE/LATCH→ARM on an accepted start, which restarts the measurement.

Top module: `gfc_freq_counter`

## Requirements
- R1: After reset, busy, gate_open, done, overflow and count are all 0.
- R2: Gate code 00 gives a window of 75 strobe periods, 01 gives 300, 10 gives 600 and 11 gives 2400. The window opens on the first strobe after the start is accepted, and gate_open stays high for exactly that many strobe periods.
- R3: A start is accepted only when the stored mode code is 00 (frequency measurement). With any other mode code, start is ignored: busy stays 0, and done and count keep their values.
- R4: Each rising edge of sig_in that falls inside the open window, with inhibit low, adds exactly one to the total reported on count.
- R5: The accumulator saturates at 2^CNT_W−1 and does not wrap. If an edge arrives while the accumulator is at that value, overflow is 1 alongside the result. Otherwise overflow is 0.
- R6: done goes to 1 in the same cycle that count takes the new total. An accepted start clears done.
- R7: While a measurement is running, count holds the previously completed result.
- R8: Edges that arrive while inhibit is 1 are not counted. The window timing is unaffected.
- R9: A start accepted during a measurement restarts it: the accumulator is cleared and the window is re-timed from the next strobe.
- R10: The gate code is captured when the start is accepted. A configuration write during a measurement does not change the current window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast counting clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_75k | input | 1 | One-cycle strobe per timebase period |
| sig_in | input | 1 | Asynchronous pulse stream to be measured |
| inhibit | input | 1 | 1 blocks counting (low-power, halt or stop state) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Input-mode code; 00 = frequency measurement |
| cfg_gate | input | 2 | Gate-length code |
| start | input | 1 | Start (or restart) pulse |
| busy | output | 1 | Measurement in progress (ARM, GATE or LATCH) |
| gate_open | output | 1 | Window is open |
| done | output | 1 | Measurement complete |
| count | output | CNT_W | Last completed edge total |
| overflow | output | 1 | Last completed total saturated |

## Verification
The hardest case to reach is saturation. With the default 20-bit width, about a million edges would be needed, far more than a short run allows. The bench therefore adds a second instance with a 6-bit accumulator and drives it with the same stimulus, so that a 70-pulse window drives it past its limit while the main instance reports the exact total. The restart and late-configuration cases are reached by issuing a start or a configuration write at a chosen offset after gate_open rises. The window length is measured by counting the clock cycles in which gate_open is high.

// File: rtl/gfc_pkg.sv
package gfc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARM   = 2'd1,
        ST_GATE  = 2'd2,
        ST_LATCH = 2'd3
    } gfc_state_e;

    localparam logic [1:0] MODE_FREQ = 2'b00;
endpackage

// File: rtl/gfc_edge_sync.sv
module gfc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/gfc_gate_timer.sv
module gfc_gate_timer #(
    parameter int GATE0 = 75,
    parameter int GATE1 = 300,
    parameter int GATE2 = 600,
    parameter int GATE3 = 2400,
    localparam int TCW  = $clog2(GATE3)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       load,
    input  logic [1:0] sel,
    input  logic       run,
    output logic       last
);
    localparam logic [TCW-1:0] LIM0 = TCW'(GATE0 - 1);
    localparam logic [TCW-1:0] LIM1 = TCW'(GATE1 - 1);
    localparam logic [TCW-1:0] LIM2 = TCW'(GATE2 - 1);
    localparam logic [TCW-1:0] LIM3 = TCW'(GATE3 - 1);

    logic [1:0]     sel_r;
    logic [TCW-1:0] tcnt;
    logic [TCW-1:0] lim;

    always_comb begin
        unique case (sel_r)
            2'b00:   lim = LIM0;
            2'b01:   lim = LIM1;
            2'b10:   lim = LIM2;
            default: lim = LIM3;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_r <= 2'b00;
            tcnt  <= '0;
        end else if (load) begin
            sel_r <= sel;
            tcnt  <= '0;
        end else if (run && tick) begin
            tcnt  <= (tcnt == lim) ? '0 : tcnt + 1'b1;
        end
    end

    assign last = run & tick & (tcnt == lim);

    AST_TCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        tcnt <= lim); // R2
    AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(sel_r)); // R10
endmodule

// File: rtl/gfc_accum.sv
module gfc_accum #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic             latch,
    output logic [CNT_W-1:0] result,
    output logic             result_ovf
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] acc;
    logic             ovf;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
            ovf <= 1'b0;
        end else if (clr) begin
            acc <= '0;
            ovf <= 1'b0;
        end else if (inc) begin
            if (acc == CNT_MAX) ovf <= 1'b1;
            else                acc <= acc + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result     <= '0;
            result_ovf <= 1'b0;
        end else if (latch) begin
            result     <= acc;
            result_ovf <= ovf;
        end
    end

    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == CNT_MAX && !clr) |=> acc == CNT_MAX); // R5
    AST_NO_STRAY_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !clr) |=> $stable(acc)); // R4
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !latch |=> ($stable(result) && $stable(result_ovf))); // R7
endmodule

// File: rtl/gfc_freq_counter.sv
module gfc_freq_counter
    import gfc_pkg::*;
#(
    parameter int CNT_W       = 20,
    parameter int SYNC_STAGES = 2,
    parameter int GATE0       = 75,
    parameter int GATE1       = 300,
    parameter int GATE2       = 600,
    parameter int GATE3       = 2400
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_75k,
    input  logic             sig_in,
    input  logic             inhibit,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_mode,
    input  logic [1:0]       cfg_gate,
    input  logic             start,
    output logic             busy,
    output logic             gate_open,
    output logic             done,
    output logic [CNT_W-1:0] count,
    output logic             overflow
);
    gfc_state_e state, state_nx;
    logic [1:0] mode_r;
    logic [1:0] gate_r;
    logic       start_ok;
    logic       rise;
    logic       gate_last;
    logic       cnt_inc;
    logic       do_latch;

    // configuration register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_r <= MODE_FREQ;
            gate_r <= 2'b00;
        end else if (cfg_we) begin
            mode_r <= cfg_mode;
            gate_r <= cfg_gate;
        end
    end

    assign start_ok = start && (mode_r == MODE_FREQ);

    gfc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sig_in),
        .rise     (rise)
    );

    gfc_gate_timer #(
        .GATE0 (GATE0), .GATE1 (GATE1), .GATE2 (GATE2), .GATE3 (GATE3)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_75k),
        .load  (start_ok),
        .sel   (gate_r),
        .run   (state == ST_GATE),
        .last  (gate_last)
    );

    assign cnt_inc  = rise && (state == ST_GATE) && !inhibit;
    assign do_latch = (state == ST_LATCH) && !start_ok;

    gfc_accum #(.CNT_W(CNT_W)) u_accum (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (start_ok),
        .inc        (cnt_inc),
        .latch      (do_latch),
        .result     (count),
        .result_ovf (overflow)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        if (start_ok) begin
            state_nx = ST_ARM;
        end else begin
            unique case (state)
                ST_IDLE:  state_nx = ST_IDLE;
                ST_ARM:   if (tick_75k)  state_nx = ST_GATE;
                ST_GATE:  if (gate_last) state_nx = ST_LATCH;
                ST_LATCH: state_nx = ST_IDLE;
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy      = (state != ST_IDLE);
        gate_open = (state == ST_GATE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        done <= 1'b0;
        else if (start_ok) done <= 1'b0;
        else if (do_latch) done <= 1'b1;
    end

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> state == ST_IDLE); // R6
    AST_DONE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(state) == ST_LATCH); // R6
    AST_MODE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && mode_r != MODE_FREQ) |=> state == ST_IDLE); // R3
    AST_GATE_AFTER_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_open) |-> $past(state) == ST_ARM); // R2
    AST_INHIBIT_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit |-> !cnt_inc); // R8
endmodule

// File: tb/gfc_freq_counter_test.sv
module gfc_freq_counter_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_75k = 1'b0;
    logic sig_in = 1'b0;
    logic inhibit = 1'b0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_mode = 2'b00;
    logic [1:0] cfg_gate = 2'b00;
    logic start = 1'b0;
    logic busy, gate_open, done, overflow;
    logic [19:0] count;
    logic s_busy, s_gate, s_done, s_ovf;
    logic [5:0] s_count;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int tdiv = 0;

    always #5 clk = ~clk;

    gfc_freq_counter uut (
        .clk(clk), .rst_n(rst_n), .tick_75k(tick_75k), .sig_in(sig_in),
        .inhibit(inhibit), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .cfg_gate(cfg_gate), .start(start), .busy(busy),
        .gate_open(gate_open), .done(done), .count(count),
        .overflow(overflow)
    );

    gfc_freq_counter #(.CNT_W(6)) uut_sat (
        .clk(clk), .rst_n(rst_n), .tick_75k(tick_75k), .sig_in(sig_in),
        .inhibit(inhibit), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .cfg_gate(cfg_gate), .start(start), .busy(s_busy),
        .gate_open(s_gate), .done(s_done), .count(s_count),
        .overflow(s_ovf)
    );

    // timebase strobe: one cycle in four
    always @(negedge clk) begin
        tdiv     <= (tdiv == 3) ? 0 : tdiv + 1;
        tick_75k <= (tdiv == 2);
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // stimulus table: gate code, pulses
    localparam int NV = 5;
    localparam int VG[NV] = '{0, 1, 2, 3, 0};
    localparam int VP[NV] = '{10, 37, 0, 50, 70};
    localparam int GLEN[4] = '{300, 1200, 2400, 9600};

    int gl, mid;

    task automatic run_meas(input int gsel, input int np, input bit inh,
                            input bit late_cfg);
        int n;
        @(negedge clk);
        cfg_mode = 2'b00; cfg_gate = gsel[1:0]; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        inhibit = inh;
        gl = 0; mid = -1; n = 0;
        while (!done && n < 20000) begin
            cfg_we = 1'b0;
            if (gate_open) begin
                sig_in = (gl < np * 4) && ((gl % 4) < 2);
                if (late_cfg && gl == 5) begin
                    cfg_gate = 2'b11; cfg_we = 1'b1;
                end
                if (gl == 10) mid = count;
                gl++;
            end else begin
                sig_in = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        sig_in = 1'b0; inhibit = 1'b0; cfg_we = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                failures++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        int prev;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 gate_open", gate_open, 0);
        chk("R1 done", done, 0);
        chk("R1 count", count, 0);
        chk("R1 overflow", overflow, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // table walk: R2 window length, R4 exact count, R6 done, R7 hold
        prev = 0;
        for (int i = 0; i < NV; i++) begin
            run_meas(VG[i], VP[i], 1'b0, 1'b0);
            chk("R2 gate length", gl, GLEN[VG[i]]);
            chk("R4 count", count, VP[i]);
            chk("R6 done", done, 1);
            chk("R7 mid-gate count", mid, prev);
            prev = VP[i];
        end
        // R5 saturation on the narrow instance after 70 pulses
        chk("R5 sat count", s_count, 63);
        chk("R5 sat overflow", s_ovf, 1);
        chk("R5 wide overflow", overflow, 0);

        // R5 overflow clears with a non-saturating result
        run_meas(0, 10, 1'b0, 1'b0);
        chk("R5 sat count small", s_count, 10);
        chk("R5 sat overflow clear", s_ovf, 0);

        // R8 inhibit masks edges but not the window
        run_meas(0, 20, 1'b1, 1'b0);
        chk("R8 inhibited count", count, 0);
        chk("R8 gate length", gl, 300);

        // R3 non-frequency mode: start ignored
        run_meas(0, 12, 1'b0, 1'b0);
        @(negedge clk);
        cfg_mode = 2'b01; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        chk("R3 busy", busy, 0);
        chk("R3 done kept", done, 1);
        chk("R3 count kept", count, 12);

        // R6 accepted start clears done
        @(negedge clk);
        cfg_mode = 2'b00; cfg_gate = 2'b00; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R6 done cleared", done, 0);
        chk("R6 busy", busy, 1);

        // R9 restart mid-window: 5 pulses then restart with 7
        while (!gate_open) @(negedge clk);
        for (int k = 0; k < 20; k++) begin
            sig_in = (k % 4) < 2;
            @(negedge clk);
        end
        sig_in = 1'b0;
        repeat (20) @(negedge clk);
        run_meas(0, 7, 1'b0, 1'b0);
        chk("R9 restarted count", count, 7);
        chk("R9 restarted length", gl, 300);

        // R10 config write during window does not change it
        run_meas(0, 9, 1'b0, 1'b1);
        chk("R10 gate length", gl, 300);
        chk("R10 count", count, 9);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule